// File: doc/BRIEF.md
# Two-Half Transmit Packet Buffer

This block holds outgoing packet data for one transmit endpoint. Its storage is split into two equal halves of one maximum packet each (64 bytes by default, 128 bytes in all). A processor or a DMA engine writes bytes, one per cycle, into whichever half is currently being filled. A separate seal strobe closes that half as one finished packet, records how many bytes it holds, and moves filling to the other half. The fill side can then build the next packet while the first one waits to be sent.

The transmitter side sees a ready flag, the byte count of the oldest sealed packet, and a random-access read port into that packet. When it pulses an acknowledge, that half is freed and the next sealed packet, if any, is presented. If no acknowledge comes, the same packet stays in place and can be sent again. When both halves hold sealed packets, the block stops accepting bytes and seals, and it withdraws its DMA request. A synchronous clear empties both halves at once.

Top module: `tx_pingpong_buf`

## Requirements
- R1: After reset, and after any cycle with `clr` high, `tx_ready` is 0, `fill_avail` is 1, `dma_req` is 1 and `ovf_flag` is 0.
- R2: Bytes accepted into a half are readable on `tx_rd_data` at addresses 0, 1, 2, ... in the order they were written, once that half is the presented packet. `tx_len` equals the number of bytes accepted.
- R3: A `pkt_end` pulse while `fill_avail` is 1 seals the fill half, so `tx_ready` is 1 in the next cycle. Later writes go to the other half, and packets are presented in the order they were sealed.
- R4: A `pkt_end` with no preceding writes yields a packet with `tx_len` equal to 0.
- R5: A byte written in the same cycle as `pkt_end` is the last byte of the sealed packet.
- R6: Once a half holds 64 bytes, further writes into it are dropped and set `ovf_flag`. The flag stays set through later seals and acknowledges until a clear or a reset, and the packet is sealed with `tx_len` equal to 64.
- R7: While both halves are sealed and not yet acknowledged, `fill_avail` and `dma_req` are 0, and both writes and `pkt_end` have no effect.
- R8: Without `tx_ack`, the presented packet keeps `tx_ready`, `tx_len` and its data. A `tx_ack` while `tx_ready` is 1 frees that half, and the next sealed packet is presented in the following cycle.
- R9: `dma_req` is 1 exactly when the fill half is free and holds fewer than 64 bytes.
- R10: `clr` discards both halves, including sealed packets that have not been sent. After the clear, a new packet starts at address 0.
- R11: A write into the fill half in the same cycle as `tx_ack` of the other half is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of both halves and the overflow flag |
| wr_en | input | 1 | Byte write strobe from processor or DMA |
| wr_data | input | 8 | Byte to write |
| pkt_end | input | 1 | Seal the fill half as one packet and switch halves |
| dma_req | output | 1 | Request for more bytes from the DMA engine |
| fill_avail | output | 1 | A free half is available for filling |
| ovf_flag | output | 1 | Sticky flag: a write was dropped because a half was full |
| tx_ready | output | 1 | A sealed packet is presented to the transmitter |
| tx_len | output | 7 | Byte count of the presented packet (0 to 64) |
| tx_rd_addr | input | 6 | Byte index into the presented packet |
| tx_rd_data | output | 8 | Byte at `tx_rd_addr` of the presented packet |
| tx_ack | input | 1 | Transmitter releases the presented packet |

## Verification
Two functions can land in the same cycle. One is the last byte write together with the seal strobe. The other is the transmitter's acknowledge of one half together with a byte write into the other half. The bench drives both strobes high in a single cycle. It then checks the sealed count and the byte at the final address against the count of writes it issued. For the second case it checks that `tx_ready` drops and that the byte written during the acknowledge appears in the next packet with the expected length.

// File: rtl/pp_pkg.sv
// Package: shared types for the two-half transmit buffer.
// Assumes exactly two halves; the half selector is one bit.
package pp_pkg;

    typedef enum logic {
        HALF_A = 1'b0,
        HALF_B = 1'b1
    } half_e;

    // Return the half opposite to h.
    function automatic half_e other_half(input half_e h);
        return (h == HALF_A) ? HALF_B : HALF_A;
    endfunction

endpackage

// File: rtl/pp_store.sv
// Module: pp_store
// Byte storage for both halves. There is one write port, addressed by the
// fill half and the byte index, and one combinational read port, addressed by
// the presented half and the transmitter's index.
// Assumes the caller only asserts we for an in-range index of a free half.
module pp_store #(
    parameter int HALF_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(HALF_BYTES),
    localparam int DEPTH     = 2 * HALF_BYTES
) (
    input  logic              clk,
    input  logic              we,
    input  pp_pkg::half_e     wr_half,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  pp_pkg::half_e     rd_half,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store the accepted byte; contents need no reset.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[{wr_half, wr_idx}] <= wr_data;
        end
    end

    // Present the requested byte of the presented half.
    always_comb begin
        rd_data = mem_q[{rd_half, rd_idx}];
    end

endmodule

// File: rtl/pp_fill_ctrl.sv
// Module: pp_fill_ctrl
// Fill-side control: selects the half being filled, counts accepted bytes,
// drops bytes past the half size (sticky overflow), and produces the seal
// strobe and the sealed length. It raises the DMA request when room remains.
// Assumes fill_free reports whether the current fill half is unsealed.
module pp_fill_ctrl #(
    parameter int HALF_BYTES = 64,
    localparam int IDX_W     = $clog2(HALF_BYTES),
    localparam int CNT_W     = $clog2(HALF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic              pkt_end,
    input  logic              fill_free,
    output pp_pkg::half_e     fill_sel,
    output logic              wr_accept,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              seal,
    output logic [CNT_W-1:0]  seal_len,
    output logic              ovf_flag,
    output logic              dma_req
);
    import pp_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HALF_BYTES);

    logic [CNT_W-1:0] cnt_q;
    half_e            sel_q;
    logic             ovf_q;
    logic             room;

    // Decide acceptance of a byte and of a seal in this cycle.
    always_comb begin
        room      = (cnt_q < LIMIT);
        wr_accept = wr_en && fill_free && room;
        seal      = pkt_end && fill_free;
        seal_len  = cnt_q + CNT_W'(wr_accept);
        wr_idx    = cnt_q[IDX_W-1:0];
        dma_req   = fill_free && room;
    end

    // Advance the byte count and switch halves on a seal.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            sel_q <= HALF_A;
        end else if (seal) begin
            cnt_q <= '0;
            sel_q <= other_half(sel_q);
        end else if (wr_accept) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Hold the overflow flag once a byte is dropped for lack of room.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf_q <= 1'b0;
        end else if (wr_en && fill_free && !room) begin
            ovf_q <= 1'b1;
        end
    end

    assign fill_sel = sel_q;
    assign ovf_flag = ovf_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);  // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q);  // R6
    AST_SEAL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (seal && !clr) |=> (cnt_q == '0) && (sel_q != $past(sel_q)));  // R3

endmodule

// File: rtl/pp_seal_track.sv
// Module: pp_seal_track
// Per-half sealed flags and lengths, and the pointer to the oldest sealed
// half, which is the one presented to the transmitter. A seal and an
// acknowledge in the same cycle always touch different halves.
// Assumes seal is only asserted while the fill half is unsealed.
module pp_seal_track #(
    parameter int HALF_BYTES = 64,
    localparam int CNT_W     = $clog2(HALF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              seal,
    input  pp_pkg::half_e     fill_sel,
    input  logic [CNT_W-1:0]  seal_len,
    input  logic              tx_ack,
    output logic              fill_free,
    output pp_pkg::half_e     send_sel,
    output logic              tx_ready,
    output logic [CNT_W-1:0]  tx_len
);
    import pp_pkg::*;

    logic [1:0]       sealed_q;
    logic [CNT_W-1:0] len_q [2];
    half_e            send_q;
    logic             release_now;

    // Release the presented half when the transmitter acknowledges it.
    always_comb begin
        release_now = tx_ack && sealed_q[send_q];
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        // Set on seal of this half, clear on its release or on a clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                sealed_q[h] <= 1'b0;
                len_q[h]    <= '0;
            end else if (seal && (fill_sel == half_e'(h))) begin
                sealed_q[h] <= 1'b1;
                len_q[h]    <= seal_len;
            end else if (release_now && (send_q == half_e'(h))) begin
                sealed_q[h] <= 1'b0;
            end
        end
    end

    // Move the presented pointer to the other half after a release.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            send_q <= HALF_A;
        end else if (release_now) begin
            send_q <= other_half(send_q);
        end
    end

    assign fill_free = !sealed_q[fill_sel];
    assign send_sel  = send_q;
    assign tx_ready  = sealed_q[send_q];
    assign tx_len    = len_q[send_q];

    AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_ack && !clr) |=> (tx_ready && $stable(tx_len)));  // R8
    AST_ACK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_ack && !clr) |=> (send_q != $past(send_q)));  // R8
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!tx_ready && fill_free));  // R10
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (tx_len <= CNT_W'(HALF_BYTES)));  // R2

endmodule

// File: rtl/tx_pingpong_buf.sv
// Module: tx_pingpong_buf
// Two-half transmit packet buffer. The fill side writes bytes and seals a
// packet with pkt_end, which swaps halves. The transmitter reads the oldest
// sealed packet and frees it with tx_ack.
// Assumes one write per cycle and a transmitter that reads by byte index.
module tx_pingpong_buf #(
    parameter int HALF_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(HALF_BYTES),
    localparam int CNT_W     = $clog2(HALF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pkt_end,
    output logic              dma_req,
    output logic              fill_avail,
    output logic              ovf_flag,
    output logic              tx_ready,
    output logic [CNT_W-1:0]  tx_len,
    input  logic [IDX_W-1:0]  tx_rd_addr,
    output logic [DATA_W-1:0] tx_rd_data,
    input  logic              tx_ack
);
    import pp_pkg::*;

    half_e            fill_sel;
    half_e            send_sel;
    logic             fill_free;
    logic             wr_accept;
    logic [IDX_W-1:0] wr_idx;
    logic             seal;
    logic [CNT_W-1:0] seal_len;

    pp_fill_ctrl #(.HALF_BYTES(HALF_BYTES)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_en     (wr_en),
        .pkt_end   (pkt_end),
        .fill_free (fill_free),
        .fill_sel  (fill_sel),
        .wr_accept (wr_accept),
        .wr_idx    (wr_idx),
        .seal      (seal),
        .seal_len  (seal_len),
        .ovf_flag  (ovf_flag),
        .dma_req   (dma_req)
    );

    pp_seal_track #(.HALF_BYTES(HALF_BYTES)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .seal      (seal),
        .fill_sel  (fill_sel),
        .seal_len  (seal_len),
        .tx_ack    (tx_ack),
        .fill_free (fill_free),
        .send_sel  (send_sel),
        .tx_ready  (tx_ready),
        .tx_len    (tx_len)
    );

    pp_store #(.HALF_BYTES(HALF_BYTES), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .we      (wr_accept),
        .wr_half (fill_sel),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_half (send_sel),
        .rd_idx  (tx_rd_addr),
        .rd_data (tx_rd_data)
    );

    assign fill_avail = fill_free;

    AST_FULL_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_avail |-> !dma_req);  // R7
    AST_FULL_NOT_READY_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_avail |-> tx_ready);  // R7

endmodule

// File: tb/tb_tx_pingpong_buf.sv
`timescale 1ns/1ps
module tb_tx_pingpong_buf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pkt_end = 1'b0;
    logic       dma_req;
    logic       fill_avail;
    logic       ovf_flag;
    logic       tx_ready;
    logic [6:0] tx_len;
    logic [5:0] tx_rd_addr = '0;
    logic [7:0] tx_rd_data;
    logic       tx_ack = 1'b0;

    int total = 0;
    int bad   = 0;

    tx_pingpong_buf dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .pkt_end    (pkt_end),
        .dma_req    (dma_req),
        .fill_avail (fill_avail),
        .ovf_flag   (ovf_flag),
        .tx_ready   (tx_ready),
        .tx_len     (tx_len),
        .tx_rd_addr (tx_rd_addr),
        .tx_rd_data (tx_rd_data),
        .tx_ack     (tx_ack)
    );

    always #2 clk = ~clk;

    // Advance one edge, then settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic put(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic seal();
        pkt_end = 1'b1;
        step();
        pkt_end = 1'b0;
    endtask

    task automatic ack();
        tx_ack = 1'b1;
        step();
        tx_ack = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        tx_rd_addr = 6'(a);
        #0.5;
        chk_eq(req, int'(tx_rd_data), exp);
    endtask

    task automatic t_reset();
        chk_eq("R1 ready", int'(tx_ready), 0);
        chk_eq("R1 avail", int'(fill_avail), 1);
        chk_eq("R1 dma", int'(dma_req), 1);
        chk_eq("R1 ovf", int'(ovf_flag), 0);
    endtask

    task automatic t_basic();
        for (int i = 0; i < 5; i++) put(8'(8'h10 + i));
        chk_eq("R3 not ready before seal", int'(tx_ready), 0);
        seal();
        chk_eq("R3 ready", int'(tx_ready), 1);
        chk_eq("R2 len", int'(tx_len), 5);
        for (int i = 0; i < 5; i++) rd_chk("R2 data", i, 8'h10 + i);
        chk_eq("R3 other half free", int'(fill_avail), 1);
    endtask

    task automatic t_full_order();
        // Packet of len 5 from t_basic still pending.
        for (int i = 0; i < 3; i++) put(8'(8'hA0 + i));
        seal();
        chk_eq("R7 avail", int'(fill_avail), 0);
        chk_eq("R7 dma", int'(dma_req), 0);
        put(8'hEE);
        seal();
        step();
        chk_eq("R8 hold ready", int'(tx_ready), 1);
        chk_eq("R3 oldest first", int'(tx_len), 5);
        rd_chk("R8 hold data", 0, 8'h10);
        ack();
        chk_eq("R8 next ready", int'(tx_ready), 1);
        chk_eq("R3 order len", int'(tx_len), 3);
        rd_chk("R3 order data", 2, 8'hA2);
        chk_eq("R7 avail after ack", int'(fill_avail), 1);
        put(8'h31); put(8'h32);
        seal();
        ack();
        chk_eq("R7 ignored write len", int'(tx_len), 2);
        rd_chk("R7 ignored write data", 0, 8'h31);
        ack();
        chk_eq("R8 empty", int'(tx_ready), 0);
    endtask

    task automatic t_zero();
        seal();
        chk_eq("R4 ready", int'(tx_ready), 1);
        chk_eq("R4 len", int'(tx_len), 0);
        ack();
        chk_eq("R4 released", int'(tx_ready), 0);
    endtask

    task automatic t_same_cycle();
        put(8'h61); put(8'h62);
        wr_en = 1'b1; wr_data = 8'h63; pkt_end = 1'b1;
        step();
        wr_en = 1'b0; pkt_end = 1'b0;
        chk_eq("R5 len", int'(tx_len), 3);
        rd_chk("R5 last byte", 2, 8'h63);
        ack();
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 63; i++) put(8'(i));
        chk_eq("R9 dma at 63", int'(dma_req), 1);
        put(8'd63);
        chk_eq("R9 dma at 64", int'(dma_req), 0);
        chk_eq("R6 no ovf yet", int'(ovf_flag), 0);
        put(8'hFF);
        chk_eq("R6 ovf", int'(ovf_flag), 1);
        seal();
        chk_eq("R6 len", int'(tx_len), 64);
        rd_chk("R6 last", 63, 63);
        rd_chk("R6 first", 0, 0);
        ack();
        chk_eq("R6 sticky", int'(ovf_flag), 1);
        clr = 1'b1; step(); clr = 1'b0;
        chk_eq("R10 ovf cleared", int'(ovf_flag), 0);
    endtask

    task automatic t_concurrent();
        put(8'h41); put(8'h42);
        seal();
        wr_en = 1'b1; wr_data = 8'h51; tx_ack = 1'b1;
        step();
        wr_en = 1'b0; tx_ack = 1'b0;
        chk_eq("R11 released", int'(tx_ready), 0);
        seal();
        chk_eq("R11 len", int'(tx_len), 1);
        rd_chk("R11 data", 0, 8'h51);
        ack();
    endtask

    task automatic t_clear();
        put(8'h71); seal();
        put(8'h72); put(8'h73); seal();
        chk_eq("R10 full before", int'(fill_avail), 0);
        clr = 1'b1; step(); clr = 1'b0;
        chk_eq("R10 ready", int'(tx_ready), 0);
        chk_eq("R1 avail after clr", int'(fill_avail), 1);
        chk_eq("R1 dma after clr", int'(dma_req), 1);
        put(8'h99); seal();
        chk_eq("R10 new len", int'(tx_len), 1);
        rd_chk("R10 new data", 0, 8'h99);
        ack();
    endtask

    initial begin
        #20000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_full_order();
        t_zero();
        t_same_cycle();
        t_overflow();
        t_concurrent();
        t_clear();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule